// File: doc/BRIEF.md
# Protected-Mode Data and Stack Segment Load Checker

This block decides whether a selector may be loaded into a data segment register or into the stack segment register while the processor runs in protected mode. A request carries a 16-bit selector, a flag that marks the stack register as the target, and the current privilege level. The base and limit of the global and local descriptor tables come in as plain inputs. The block picks the table, checks the selector against that table's limit, and fetches the 8-byte descriptor as two 32-bit words over a simple request/acknowledge read port. It then applies the type and privilege rules.

Each accepted request ends in exactly one completion cycle. In that cycle the block either grants the load and presents the two descriptor words for the segment cache, or it raises a fault with an exception vector and a 16-bit error code. When several rules are broken, only the first one in the fixed check order is reported. Loads of the code segment register, virtual-8086 mode and updates to the descriptor's accessed bit are handled elsewhere.

Top module: `seg_load_checker`

## Requirements
- R1: A selector whose bits 15:2 are all zero is null. A null selector aimed at the stack register faults with vector 13 and error code 0. A null selector aimed at a data register is granted with both descriptor words zero. In both cases no memory read is issued.
- R2: Selector bit 2 picks the table: 1 selects the local table and 0 selects the global table. The descriptor address is the table base plus the selector with bits 2:0 cleared. The low word is read at that address, then the high word at address plus 4, in that order, and the address is held until each read is acknowledged.
- R3: If the selector offset (bits 2:0 cleared) plus 7 is greater than the chosen table's limit, the request faults with vector 13 and no read is issued. An offset plus 7 equal to the limit is accepted.
- R4: If high-word bit 12 (code/data descriptor flag) is clear, the request faults with vector 13.
- R5: For the stack register, the request faults with vector 13 if high-word bit 11 (code) is set or bit 9 (writable) is clear. It also faults with vector 13 if selector bits 1:0 (RPL) differ from the current privilege level, or if high-word bits 14:13 (DPL) differ from it.
- R6: For a data register, a code descriptor (bit 11 set) with bit 9 (readable) clear faults with vector 13.
- R7: For a data register, if the descriptor is data, or code with bit 10 (conforming) clear, the request faults with vector 13 when DPL is below the current privilege level or below RPL. Conforming code is exempt from this test.
- R8: If high-word bit 15 (present) is clear, the request faults with vector 12 for the stack register and vector 11 for a data register. A granted non-null load therefore always carries bit 15 set.
- R9: Every fault except the null stack case reports the selector with bits 1:0 cleared as its error code.
- R10: `start` is taken only while `busy` is low; a `start` raised while `busy` is high is ignored. Each accepted request produces exactly one one-cycle `done` pulse. In that cycle exactly one of `load_ok` and `fault` is high, and neither is high outside it. On a grant, `desc_lo` and `desc_hi` carry the fetched words.
- R11: The checks run in a fixed order: null, limit, code/data flag, type, privilege, present. Only the first failure is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when busy is low |
| sel_in | input | 16 | Selector to load |
| to_stack | input | 1 | 1 = target is the stack register, 0 = a data register |
| cpl_in | input | 2 | Current privilege level |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | LIM_W | Global table limit (last valid byte offset) |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | LIM_W | Local table limit |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Read byte address |
| mem_ack | input | 1 | Read acknowledge, one cycle, carries data |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| load_ok | output | 1 | Load granted (only with done) |
| fault | output | 1 | Fault raised (only with done) |
| fault_vec | output | 8 | Exception vector: 13, 12 or 11 |
| fault_code | output | 16 | Fault error code |
| desc_lo | output | 32 | Low descriptor word for the cache |
| desc_hi | output | 32 | High descriptor word for the cache |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high, as a single-cycle pulse. They also assume that the table bases and limits stay constant while a request is in progress. The bench's memory responder acknowledges only an outstanding request, for one cycle, sometimes after an extra wait cycle. The table registers are set once before the first request and never changed. One case deliberately holds `start` high for a second cycle with a different selector while the block is busy, so the ignored-start rule is exercised without breaking those assumptions.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int DESC_W = 32;

    localparam logic [7:0] VEC_GPROT  = 8'd13;
    localparam logic [7:0] VEC_STACK  = 8'd12;
    localparam logic [7:0] VEC_ABSENT = 8'd11;

    localparam int HB_PRESENT = 15;
    localparam int HB_DPL_LO  = 13;
    localparam int HB_USER    = 12;
    localparam int HB_CODE    = 11;
    localparam int HB_CONF    = 10;
    localparam int HB_RW      = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FETCH
    } ctl_state_t;

    typedef struct packed {
        logic [15:0] sel;
        logic        stack;
        logic [1:0]  cpl;
    } load_req_t;

    typedef struct packed {
        logic              fault;
        logic [7:0]        vec;
        logic [15:0]       code;
        logic [DESC_W-1:0] lo;
        logic [DESC_W-1:0] hi;
    } verdict_t;

    function automatic logic sel_is_null(input logic [15:0] s);
        return s[15:2] == 14'd0;
    endfunction

    function automatic logic [15:0] sel_err_code(input logic [15:0] s);
        return {s[15:2], 2'b00};
    endfunction

    function automatic verdict_t make_fault(input logic [7:0] v, input logic [15:0] c);
        verdict_t r;
        r.fault = 1'b1;
        r.vec   = v;
        r.code  = c;
        r.lo    = '0;
        r.hi    = '0;
        return r;
    endfunction

    function automatic verdict_t make_grant(input logic [DESC_W-1:0] l, input logic [DESC_W-1:0] h);
        verdict_t r;
        r.fault = 1'b0;
        r.vec   = 8'd0;
        r.code  = 16'd0;
        r.lo    = l;
        r.hi    = h;
        return r;
    endfunction

endpackage

// File: rtl/seg_table_sel.sv
module seg_table_sel
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 32
) (
    input  logic [15:0]       sel,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [LIM_W-1:0]  glimit,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [LIM_W-1:0]  llimit,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              in_bounds
);
    localparam int CMP_W = ((LIM_W > 16) ? LIM_W : 16) + 1;

    logic [15:0]       offset;
    logic [ADDR_W-1:0] base_pick;
    logic [LIM_W-1:0]  lim_pick;
    logic [CMP_W-1:0]  last_byte;
    logic [CMP_W-1:0]  lim_wide;

    always_comb begin
        offset    = {sel[15:3], 3'b000};
        base_pick = sel[2] ? lbase  : gbase;
        lim_pick  = sel[2] ? llimit : glimit;
        last_byte = CMP_W'(offset) + CMP_W'(7);
        lim_wide  = CMP_W'(lim_pick);
        in_bounds = (last_byte <= lim_wide);
        desc_addr = base_pick + ADDR_W'(offset);
    end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NWORDS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [ADDR_W-1:0]        base_addr,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_ack,
    input  logic [DESC_W-1:0]        mem_rdata,
    output logic [NWORDS*DESC_W-1:0] words,
    output logic                     done
);
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(NWORDS - 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_W / 8);

    logic              active;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            addr_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    idx    <= '0;
                    addr_q <= base_addr;
                end
            end else if (mem_ack) begin
                if (idx == LAST) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx    <= idx + 1'b1;
                    addr_q <= addr_q + STEP;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NWORDS; g++) begin : g_word
            logic [DESC_W-1:0] wq;
            always_ff @(posedge clk) begin
                if (rst)
                    wq <= '0;
                else if (active && mem_ack && idx == IDX_W'(g))
                    wq <= mem_rdata;
            end
            assign words[g*DESC_W +: DESC_W] = wq;
        end
    endgenerate

    assign mem_req  = active;
    assign mem_addr = addr_q;
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
    import seg_chk_pkg::*;
(
    input  logic [DESC_W-1:0] hi,
    input  logic              stack,
    input  logic [1:0]        cpl,
    input  logic [1:0]        rpl,
    output logic              fail,
    output logic [7:0]        vec
);
    logic [1:0] dpl;
    logic       is_code, is_conf, rw, user_seg, present;
    logic       bad_user, bad_type, bad_priv;

    always_comb begin
        dpl      = hi[HB_DPL_LO +: 2];
        is_code  = hi[HB_CODE];
        is_conf  = hi[HB_CONF];
        rw       = hi[HB_RW];
        user_seg = hi[HB_USER];
        present  = hi[HB_PRESENT];

        bad_user = !user_seg;
        if (stack) begin
            bad_type = is_code || !rw;
            bad_priv = (rpl != cpl) || (dpl != cpl);
        end else begin
            bad_type = is_code && !rw;
            bad_priv = (!is_code || !is_conf) && ((dpl < cpl) || (dpl < rpl));
        end

        fail = 1'b1;
        vec  = VEC_GPROT;
        if (bad_user || bad_type || bad_priv) begin
            vec = VEC_GPROT;
        end else if (!present) begin
            vec = stack ? VEC_STACK : VEC_ABSENT;
        end else begin
            fail = 1'b0;
            vec  = 8'd0;
        end
    end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       sel_in,
    input  logic              to_stack,
    input  logic [1:0]        cpl_in,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              load_ok,
    output logic              fault,
    output logic [7:0]        fault_vec,
    output logic [15:0]       fault_code,
    output logic [31:0]       desc_lo,
    output logic [31:0]       desc_hi
);
    localparam int NWORDS = 2;

    ctl_state_t              st;
    load_req_t               rq;
    verdict_t                res;
    logic                    done_q;
    logic [ADDR_W-1:0]       tab_addr;
    logic                    tab_ok;
    logic                    fetch_go;
    logic                    fetch_done;
    logic [NWORDS*DESC_W-1:0] fwords;
    logic [DESC_W-1:0]       w_lo, w_hi;
    logic                    rt_fail;
    logic [7:0]              rt_vec;

    seg_table_sel #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_tab (
        .sel       (rq.sel),
        .gbase     (gdt_base),
        .glimit    (gdt_limit),
        .lbase     (ldt_base),
        .llimit    (ldt_limit),
        .desc_addr (tab_addr),
        .in_bounds (tab_ok)
    );

    assign fetch_go = (st == ST_EVAL) && !sel_is_null(rq.sel) && tab_ok;

    seg_desc_fetch #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (fetch_go),
        .base_addr (tab_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .words     (fwords),
        .done      (fetch_done)
    );

    assign w_lo = fwords[0 +: DESC_W];
    assign w_hi = fwords[DESC_W +: DESC_W];

    seg_rights_check u_rights (
        .hi    (w_hi),
        .stack (rq.stack),
        .cpl   (rq.cpl),
        .rpl   (rq.sel[1:0]),
        .fail  (rt_fail),
        .vec   (rt_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            rq     <= '0;
            res    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        rq.sel   <= sel_in;
                        rq.stack <= to_stack;
                        rq.cpl   <= cpl_in;
                        st       <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (sel_is_null(rq.sel)) begin
                        res    <= rq.stack ? make_fault(VEC_GPROT, 16'd0)
                                           : make_grant('0, '0);
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (!tab_ok) begin
                        res    <= make_fault(VEC_GPROT, sel_err_code(rq.sel));
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        res    <= rt_fail ? make_fault(rt_vec, sel_err_code(rq.sel))
                                          : make_grant(w_lo, w_hi);
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign load_ok    = done_q && !res.fault;
    assign fault      = done_q && res.fault;
    assign fault_vec  = res.vec;
    assign fault_code = res.code;
    assign desc_lo    = res.lo;
    assign desc_hi    = res.hi;
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [15:0]       sel_in,
    input logic              to_stack,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              done,
    input logic              load_ok,
    input logic              fault,
    input logic [7:0]        fault_vec,
    input logic [15:0]       fault_code,
    input logic [31:0]       desc_lo,
    input logic [31:0]       desc_hi
);
    AST_NULL_STACK: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && to_stack && sel_in[15:2] == 14'd0)
        |-> ##2 (done && fault && fault_vec == 8'd13 && fault_code == 16'd0)); // R1

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2

    AST_PRESENT_GRANT: assert property (@(posedge clk) disable iff (rst)
        load_ok |-> (desc_hi[15] || (desc_hi == 32'd0 && desc_lo == 32'd0))); // R8

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_vec == 8'd13 || fault_vec == 8'd12 || fault_vec == 8'd11)); // R8

    AST_CODE_LOW: assert property (@(posedge clk) disable iff (rst)
        fault |-> (fault_code[1:0] == 2'b00)); // R9

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> (load_ok != fault)); // R10

    AST_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!load_ok && !fault)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R10
endmodule

bind seg_load_checker seg_load_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sel_in     (sel_in),
    .to_stack   (to_stack),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .done       (done),
    .load_ok    (load_ok),
    .fault      (fault),
    .fault_vec  (fault_vec),
    .fault_code (fault_code),
    .desc_lo    (desc_lo),
    .desc_hi    (desc_hi)
);

// File: tb/sim_seg_load_checker.sv
`timescale 1ns/1ps
module sim_seg_load_checker;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 32;
    localparam logic [31:0] GBASE = 32'h0000_0100;
    localparam logic [31:0] GLIM  = 32'h0000_007F;
    localparam logic [31:0] LBASE = 32'h0000_0400;
    localparam logic [31:0] LLIM  = 32'h0000_003F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [15:0] sel_in = '0;
    logic to_stack = 1'b0;
    logic [1:0] cpl_in = '0;
    logic [31:0] gdt_base = GBASE, ldt_base = LBASE;
    logic [31:0] gdt_limit = GLIM, ldt_limit = LLIM;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic busy, done, load_ok, fault;
    logic [7:0] fault_vec;
    logic [15:0] fault_code;
    logic [31:0] desc_lo, desc_hi;

    seg_load_checker #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] mem [0:1023];
    logic [31:0] addr_q [$];
    int wait_cnt = 0;
    bit slow = 1'b0;

    bit pending = 1'b0, got = 1'b0;
    int unexpected = 0, stray = 0;
    logic c_load, c_fault;
    logic [7:0] c_vec;
    logic [15:0] c_code;
    logic [31:0] c_lo, c_hi;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    // memory responder: single-cycle acknowledge, optional extra wait cycle
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt != 0) begin
                wait_cnt--;
            end else begin
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[11:2]];
                addr_q.push_back(mem_addr);
                wait_cnt = slow ? 1 : 0;
            end
        end
    end

    // per-clock monitor against the bench's outstanding-request model
    always @(negedge clk) begin
        if (!rst) begin
            if (!done && (load_ok || fault)) stray++;
            if (done) begin
                if (!pending) begin
                    unexpected++;
                end else begin
                    c_load = load_ok; c_fault = fault; c_vec = fault_vec;
                    c_code = fault_code; c_lo = desc_lo; c_hi = desc_hi;
                    got = 1'b1;
                    pending = 1'b0;
                end
            end
        end
    end

    task automatic run_case(input string rq, input logic [15:0] sel, input bit stk,
                            input logic [1:0] cpl, input logic [31:0] hi, input bit hold2);
        logic [31:0] base, lim, off, daddr, lo;
        logic e_fault, e_gp;
        logic [7:0] e_vec;
        logic [15:0] e_code;
        logic [31:0] e_lo, e_hi;
        int e_reads;
        logic [1:0] dpl;

        base = sel[2] ? LBASE : GBASE;
        lim  = sel[2] ? LLIM : GLIM;
        off  = {16'd0, sel[15:3], 3'b000};
        daddr = base + off;
        lo = {sel, 16'h3C5A} ^ {16'h0, hi[15:0]};
        dpl = hi[14:13];

        e_fault = 1'b0; e_gp = 1'b0; e_vec = 8'd0; e_code = {sel[15:2], 2'b00};
        e_lo = lo; e_hi = hi; e_reads = 2;
        if (sel[15:2] == 14'd0) begin
            e_reads = 0; e_lo = 0; e_hi = 0;
            if (stk) begin e_fault = 1; e_vec = 8'd13; e_code = 16'd0; end
        end else if (off + 7 > lim) begin
            e_reads = 0; e_fault = 1; e_vec = 8'd13;
        end else begin
            if (!hi[12]) e_gp = 1;
            else if (stk) begin
                if (hi[11] || !hi[9]) e_gp = 1;
                else if (sel[1:0] != cpl || dpl != cpl) e_gp = 1;
            end else begin
                if (hi[11] && !hi[9]) e_gp = 1;
                else if (!(hi[11] && hi[10]) && (dpl < cpl || dpl < sel[1:0])) e_gp = 1;
            end
            if (e_gp) begin e_fault = 1; e_vec = 8'd13; end
            else if (!hi[15]) begin e_fault = 1; e_vec = stk ? 8'd12 : 8'd11; end
            if (e_fault) begin
                e_lo = 0; e_hi = 0;
            end
            mem[daddr[11:2]] = lo;
            mem[daddr[11:2] + 10'd1] = hi;
        end

        addr_q.delete();
        got = 1'b0;
        pending = 1'b1;
        sel_in = sel; to_stack = stk; cpl_in = cpl; start = 1'b1;
        @(negedge clk);
        if (hold2) begin
            sel_in = 16'h0000; to_stack = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk); #1;
        end
        for (int i = 0; i < 4; i++) @(negedge clk);

        chk({rq, " R10"}, "done seen", got, 1'b1);
        chk(rq, "fault", c_fault, e_fault);
        chk(rq, "load_ok", c_load, !e_fault);
        if (e_fault) begin
            chk(rq, "vector", c_vec, e_vec);
            chk({rq, " R9"}, "error code", c_code, e_code);
        end else begin
            chk(rq, "desc_lo", c_lo, e_lo);
            chk(rq, "desc_hi", c_hi, e_hi);
        end
        chk({rq, " R2"}, "read count", addr_q.size(), e_reads);
        if (e_reads == 2 && addr_q.size() == 2) begin
            chk("R2", "low word address", addr_q[0], daddr);
            chk("R2", "high word address", addr_q[1], daddr + 32'd4);
        end
        slow = ~slow;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", busy, 1'b0);
        chk("R10", "done in reset", done, 1'b0);
        chk("R2", "mem_req in reset", mem_req, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // R1 null selectors
        run_case("R1 null data", 16'h0003, 1'b0, 2'd0, 32'h0, 1'b0);
        run_case("R1 null stack", 16'h0002, 1'b1, 2'd2, 32'h0, 1'b0);
        // R2 table select and order
        run_case("R2 global data", 16'h0010, 1'b0, 2'd0, 32'h0000_9200, 1'b0);
        run_case("R2 local data", 16'h000C, 1'b0, 2'd3, 32'h0000_F200, 1'b0);
        // R3 limit
        run_case("R3 global past limit", 16'h0080, 1'b0, 2'd0, 32'h0000_9200, 1'b0);
        run_case("R3 local past limit", 16'h0047, 1'b0, 2'd0, 32'h0000_9200, 1'b0);
        run_case("R3 last entry", 16'h0078, 1'b0, 2'd0, 32'h0000_9200, 1'b0);
        // R4 system descriptor
        run_case("R4 system desc", 16'h0018, 1'b0, 2'd0, 32'h0000_8200, 1'b0);
        // R5 stack rules
        run_case("R5 stack code", 16'h0020, 1'b1, 2'd0, 32'h0000_9A00, 1'b0);
        run_case("R5 stack readonly", 16'h0028, 1'b1, 2'd0, 32'h0000_9000, 1'b0);
        run_case("R5 stack rpl", 16'h0031, 1'b1, 2'd0, 32'h0000_9200, 1'b0);
        run_case("R5 stack dpl", 16'h0038, 1'b1, 2'd0, 32'h0000_B200, 1'b0);
        run_case("R5 stack ok", 16'h0043, 1'b1, 2'd3, 32'h0000_F200, 1'b0);
        // R6 execute-only code into data register
        run_case("R6 exec only", 16'h0048, 1'b0, 2'd0, 32'h0000_9800, 1'b0);
        run_case("R6 readable code", 16'h0050, 1'b0, 2'd0, 32'h0000_9A00, 1'b0);
        // R7 privilege for data registers
        run_case("R7 dpl below cpl", 16'h0058, 1'b0, 2'd3, 32'h0000_9200, 1'b0);
        run_case("R7 dpl below rpl", 16'h0062, 1'b0, 2'd0, 32'h0000_B200, 1'b0);
        run_case("R7 conforming exempt", 16'h0068, 1'b0, 2'd3, 32'h0000_9E00, 1'b0);
        // R8 present
        run_case("R8 data absent", 16'h0070, 1'b0, 2'd0, 32'h0000_1200, 1'b0);
        run_case("R8 stack absent", 16'h0014, 1'b1, 2'd0, 32'h0000_1200, 1'b0);
        // R11 priority among failures
        run_case("R11 system before absent", 16'h001C, 1'b0, 2'd0, 32'h0000_0200, 1'b0);
        run_case("R11 priv before absent", 16'h0024, 1'b1, 2'd0, 32'h0000_3200, 1'b0);
        run_case("R11 type before priv", 16'h002C, 1'b0, 2'd3, 32'h0000_9800, 1'b0);
        // R10 start while busy is ignored (second start has a null stack selector)
        run_case("R10 start while busy", 16'h0034, 1'b0, 2'd0, 32'h0000_9200, 1'b1);

        chk("R10", "done without request", unexpected, 0);
        chk("R10", "outcome outside done", stray, 0);
        finish_run();
    end
endmodule